// File: doc/BRIEF.md
# Virtual Address Attribute Resolver

This block takes one memory access request from the processor or from the DMA engine and resolves the final attributes of that access. The request carries a 32-bit virtual address, a region tag, the privilege level, the access direction and the fields of the translation entry that an upstream lookup has already matched. The block then produces the physical address, the cache policy, the on-chip RAM and control-register selects, the space-attribute and timing values for the external interface area, and two flags: one for a protection violation and one for a translation miss.

Regions tagged as mapped go through the page translation, and the page size can be 1 KB, 4 KB, 64 KB or 1 MB. Regions tagged as fixed pass the address through unchanged. Some address windows, chosen by region, mode and an operand-RAM enable, override these defaults. One request is accepted per cycle when the output stage is free. Its result is registered and offered to the consumer with a valid/ready handshake.

Top module: `va_attr_resolver`

## Requirements
- R1: A translated access keeps the low offset bits of the virtual address and takes every bit above them from the entry's page number, which supplies physical bits 31:10. The page-size code sets the offset width: 2'b00 gives 10 bits, 2'b01 gives 12, 2'b10 gives 16 and 2'b11 gives 20.
- R2: rsp_cacheable is 1 only when all of these hold: the access is translated and hits, cache_on is 1, tlb_cache is 1, and the access is not a control-register access. Untranslated accesses and on-chip RAM accesses are never cacheable.
- R3: rsp_wthru equals rsp_cacheable AND req_write AND tlb_wthru. Reads and copy-back pages (tlb_wthru = 0) report 0.
- R4: Region tags are P0=0, P1=1, P2=2, P3=3, P4=4 and U0=5. When oram_on is 1 and the region is P0 or U0 with vaddr[31:26] = 6'h1F, the access selects on-chip RAM. In that case there is no translation, no miss even without a hit, rsp_paddr equals the virtual address, and every access width is accepted the same way.
- R5: A region tag other than P0, P3 or U0 is untranslated and rsp_paddr equals the virtual address. The one exception is a P4 access with vaddr[31:26] = 6'h38 (the store-queue window), which is translated like a mapped region.
- R6: A translated, hitting access whose physical bits 28:26 equal 3'b111 sets rsp_ctrl.
- R7: A control-register access whose page has tlb_cache = 1 sets rsp_violation and forces rsp_cacheable to 0.
- R8: rsp_space and rsp_timing come from dma_space and dma_timing for a DMA request. For a processor request they come from tlb_space and tlb_timing when the access is translated, and they are 0 otherwise. On a miss they are 0.
- R9: A processor request that is untranslated, does not select on-chip RAM, and has vaddr[28:26] equal to 3'd5 or 3'd6 (the external interface area) sets rsp_violation. A DMA request to the same address does not.
- R10: A translated request with tlb_hit = 0 sets rsp_miss. It then drives rsp_paddr, rsp_cacheable, rsp_wthru, rsp_ctrl, rsp_space and rsp_timing to 0.
- R11: req_ready equals (NOT rsp_valid) OR rsp_ready. The result of an accepted request appears with rsp_valid on the next cycle. All response outputs hold while rsp_valid is 1 and rsp_ready is 0.
- R12: After synchronous reset, rsp_valid is 0.
- R13: A processor request with req_user = 1 whose region is not U0 sets rsp_violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_vaddr | input | 32 | Virtual address |
| req_region | input | 3 | Region tag (P0=0, P1=1, P2=2, P3=3, P4=4, U0=5) |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_write | input | 1 | 1 = write access |
| req_dma | input | 1 | 1 = request from DMA engine |
| tlb_hit | input | 1 | Matched entry is valid |
| tlb_pg_size | input | 2 | Page size code |
| tlb_ppn | input | 22 | Physical page number (physical bits 31:10) |
| tlb_cache | input | 1 | Page cacheable bit |
| tlb_wthru | input | 1 | Page write-through bit |
| tlb_space | input | 3 | Page space attribute |
| tlb_timing | input | 1 | Page timing control |
| dma_space | input | 3 | DMA channel space attribute |
| dma_timing | input | 1 | DMA channel timing control |
| cache_on | input | 1 | Global cache enable |
| oram_on | input | 1 | Operand cache used as on-chip RAM |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Access uses the cache |
| rsp_wthru | output | 1 | Cacheable write uses write-through |
| rsp_oram | output | 1 | On-chip RAM selected |
| rsp_ctrl | output | 1 | Control-register area access |
| rsp_space | output | 3 | Resolved space attribute |
| rsp_timing | output | 1 | Resolved timing control |
| rsp_violation | output | 1 | Access violation |
| rsp_miss | output | 1 | Translation miss |

## Verification
All state lives in the response register and its valid bit, so any corruption of that state shows up at the ports on the cycle it happens. A stuck valid bit lowers req_ready and stalls the requester at once. A result register that is not loaded or not held shows up in rsp_paddr or a flag on the first cycle after the accept or the stall. A fault in window classification shows up only for addresses in the windows concerned. For that reason the stimulus steers addresses into the on-chip RAM, store-queue, interface and control-register windows instead of relying on uniform random values. Stalls are inserted at random so that every field is checked while it is being held.

// File: rtl/va_attr_pkg.sv
package va_attr_pkg;

    localparam int VA_W   = 32;
    localparam int PG_MIN = 10;
    localparam int PPN_W  = VA_W - PG_MIN;
    localparam int SA_W   = 3;
    localparam int TC_W   = 1;

    typedef enum logic [2:0] {
        RGN_P0 = 3'd0,
        RGN_P1 = 3'd1,
        RGN_P2 = 3'd2,
        RGN_P3 = 3'd3,
        RGN_P4 = 3'd4,
        RGN_U0 = 3'd5
    } region_e;

    typedef enum logic [1:0] {
        PG_1K  = 2'b00,
        PG_4K  = 2'b01,
        PG_64K = 2'b10,
        PG_1M  = 2'b11
    } pg_size_e;

    typedef struct packed {
        logic xlate;
        logic oram;
        logic ifa_viol;
        logic mode_viol;
    } win_t;

    typedef struct packed {
        logic [VA_W-1:0] paddr;
        logic            cacheable;
        logic            wthru;
        logic            oram;
        logic            ctrl;
        logic [SA_W-1:0] space;
        logic [TC_W-1:0] timing;
        logic            violation;
        logic            miss;
    } attr_t;

    function automatic int unsigned offset_bits(pg_size_e sz);
        case (sz)
            PG_1K:   return 10;
            PG_4K:   return 12;
            PG_64K:  return 16;
            default: return 20;
        endcase
    endfunction

    function automatic logic is_mapped(region_e r);
        return (r == RGN_P0) || (r == RGN_P3) || (r == RGN_U0);
    endfunction

endpackage

// File: rtl/va_page_merge.sv
module va_page_merge
    import va_attr_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PPN_W-1:0] ppn,
    input  pg_size_e         pg_size,
    output logic [VA_W-1:0]  paddr
);

    localparam int unsigned OFFS_LIMIT = 20;

    logic [VA_W-1:0] page_base;
    int unsigned     offs;

    assign page_base = {ppn, {PG_MIN{1'b0}}};
    assign offs      = offset_bits(pg_size);

    genvar b;
    generate
        for (b = 0; b < VA_W; b++) begin : g_bit
            if (b < PG_MIN) begin : g_always_offset
                assign paddr[b] = vaddr[b];
            end else if (b < OFFS_LIMIT) begin : g_size_dep
                assign paddr[b] = (b < offs) ? vaddr[b] : page_base[b];
            end else begin : g_always_page
                assign paddr[b] = page_base[b];
            end
        end
    endgenerate

endmodule

// File: rtl/va_classify.sv
module va_classify
    import va_attr_pkg::*;
#(
    parameter logic [5:0] ORAM_TAG = 6'h1F,
    parameter logic [5:0] SQ_TAG   = 6'h38,
    parameter logic [2:0] IFA_LO   = 3'd5,
    parameter logic [2:0] IFA_HI   = 3'd6
) (
    input  logic [5:0] vtop,
    input  region_e    region,
    input  logic       user_mode,
    input  logic       is_dma,
    input  logic       oram_on,
    output win_t       win
);

    logic mapped;
    logic oram_hit;
    logic sq_hit;
    logic in_ifa;

    always_comb begin
        mapped   = is_mapped(region);
        oram_hit = oram_on && ((region == RGN_P0) || (region == RGN_U0))
                   && (vtop == ORAM_TAG);
        sq_hit   = (region == RGN_P4) && (vtop == SQ_TAG);
        in_ifa   = (vtop[2:0] >= IFA_LO) && (vtop[2:0] <= IFA_HI);

        win.xlate     = (mapped && !oram_hit) || sq_hit;
        win.oram      = oram_hit;
        win.ifa_viol  = !mapped && !sq_hit && !is_dma && in_ifa;
        win.mode_viol = user_mode && !is_dma && (region != RGN_U0);
    end

endmodule

// File: rtl/va_policy.sv
module va_policy
    import va_attr_pkg::*;
#(
    parameter logic [2:0] CREG_AREA = 3'b111
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] merged,
    input  win_t            win,
    input  logic            is_write,
    input  logic            is_dma,
    input  logic            tlb_hit,
    input  logic            tlb_cache,
    input  logic            tlb_wthru,
    input  logic [SA_W-1:0] tlb_space,
    input  logic [TC_W-1:0] tlb_timing,
    input  logic [SA_W-1:0] dma_space,
    input  logic [TC_W-1:0] dma_timing,
    input  logic            cache_on,
    output attr_t           attr
);

    logic good;
    logic miss;
    logic creg;
    logic creg_bad;

    always_comb begin
        good     = win.xlate && tlb_hit;
        miss     = win.xlate && !tlb_hit;
        creg     = good && (merged[28:26] == CREG_AREA);
        creg_bad = creg && tlb_cache;

        attr = '0;
        attr.miss      = miss;
        attr.oram      = win.oram;
        attr.ctrl      = creg;
        attr.violation = win.ifa_viol || win.mode_viol || creg_bad;
        attr.cacheable = good && cache_on && tlb_cache && !creg;
        attr.wthru     = good && cache_on && tlb_cache && !creg
                         && is_write && tlb_wthru;

        if (miss) begin
            attr.paddr = '0;
        end else if (win.xlate) begin
            attr.paddr = merged;
        end else begin
            attr.paddr = vaddr;
        end

        if (!miss) begin
            if (is_dma) begin
                attr.space  = dma_space;
                attr.timing = dma_timing;
            end else if (win.xlate) begin
                attr.space  = tlb_space;
                attr.timing = tlb_timing;
            end
        end
    end

endmodule

// File: rtl/va_rsp_reg.sv
module va_rsp_reg #(
    parameter type T = logic
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  T     in_data,
    output logic out_valid,
    input  logic out_ready,
    output T     out_data
);

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/va_attr_resolver.sv
module va_attr_resolver
    import va_attr_pkg::*;
#(
    parameter logic [5:0] ORAM_TAG  = 6'h1F,
    parameter logic [5:0] SQ_TAG    = 6'h38,
    parameter logic [2:0] CREG_AREA = 3'b111
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [2:0]       req_region,
    input  logic             req_user,
    input  logic             req_write,
    input  logic             req_dma,
    input  logic             tlb_hit,
    input  logic [1:0]       tlb_pg_size,
    input  logic [PPN_W-1:0] tlb_ppn,
    input  logic             tlb_cache,
    input  logic             tlb_wthru,
    input  logic [SA_W-1:0]  tlb_space,
    input  logic [TC_W-1:0]  tlb_timing,
    input  logic [SA_W-1:0]  dma_space,
    input  logic [TC_W-1:0]  dma_timing,
    input  logic             cache_on,
    input  logic             oram_on,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             rsp_cacheable,
    output logic             rsp_wthru,
    output logic             rsp_oram,
    output logic             rsp_ctrl,
    output logic [SA_W-1:0]  rsp_space,
    output logic [TC_W-1:0]  rsp_timing,
    output logic             rsp_violation,
    output logic             rsp_miss
);

    logic [VA_W-1:0] merged;
    win_t            win;
    attr_t           nxt;
    attr_t           cur;

    va_page_merge i_merge (
        .vaddr   (req_vaddr),
        .ppn     (tlb_ppn),
        .pg_size (pg_size_e'(tlb_pg_size)),
        .paddr   (merged)
    );

    va_classify #(
        .ORAM_TAG (ORAM_TAG),
        .SQ_TAG   (SQ_TAG)
    ) i_class (
        .vtop      (req_vaddr[VA_W-1:VA_W-6]),
        .region    (region_e'(req_region)),
        .user_mode (req_user),
        .is_dma    (req_dma),
        .oram_on   (oram_on),
        .win       (win)
    );

    va_policy #(
        .CREG_AREA (CREG_AREA)
    ) i_policy (
        .vaddr      (req_vaddr),
        .merged     (merged),
        .win        (win),
        .is_write   (req_write),
        .is_dma     (req_dma),
        .tlb_hit    (tlb_hit),
        .tlb_cache  (tlb_cache),
        .tlb_wthru  (tlb_wthru),
        .tlb_space  (tlb_space),
        .tlb_timing (tlb_timing),
        .dma_space  (dma_space),
        .dma_timing (dma_timing),
        .cache_on   (cache_on),
        .attr       (nxt)
    );

    va_rsp_reg #(
        .T (attr_t)
    ) i_rsp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   (nxt),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_data  (cur)
    );

    assign rsp_paddr     = cur.paddr;
    assign rsp_cacheable = cur.cacheable;
    assign rsp_wthru     = cur.wthru;
    assign rsp_oram      = cur.oram;
    assign rsp_ctrl      = cur.ctrl;
    assign rsp_space     = cur.space;
    assign rsp_timing    = cur.timing;
    assign rsp_violation = cur.violation;
    assign rsp_miss      = cur.miss;

endmodule

// File: rtl/va_attr_resolver_chk.sv
module va_attr_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_paddr,
    input logic        rsp_cacheable,
    input logic        rsp_wthru,
    input logic        rsp_oram,
    input logic        rsp_ctrl,
    input logic        rsp_violation,
    input logic        rsp_miss
);

    assert_accept_latency_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> rsp_valid);

    assert_hold_stall_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_cacheable) && $stable(rsp_violation) && $stable(rsp_miss));

    assert_wthru_needs_cache_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_wthru |-> rsp_cacheable);

    assert_ctrl_uncached_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ctrl |-> !rsp_cacheable);

    assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_miss |-> (rsp_paddr == 32'h0) && !rsp_cacheable && !rsp_ctrl);

    assert_oram_no_miss_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_oram |-> !rsp_miss && !rsp_cacheable && !rsp_ctrl);

    assert_cache_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_cacheable |-> !rsp_oram && !rsp_miss);

endmodule

bind va_attr_resolver va_attr_resolver_chk i_chk (.*);

// File: tb/test_va_attr_resolver.sv
module test_va_attr_resolver;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        req_valid = 0, req_user = 0, req_write = 0, req_dma = 0;
    logic [31:0] req_vaddr = 0;
    logic [2:0]  req_region = 0;
    logic        tlb_hit = 0, tlb_cache = 0, tlb_wthru = 0, tlb_timing = 0;
    logic [1:0]  tlb_pg_size = 0;
    logic [21:0] tlb_ppn = 0;
    logic [2:0]  tlb_space = 0, dma_space = 0;
    logic        dma_timing = 0, cache_on = 0, oram_on = 0, rsp_ready = 1;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_cacheable, rsp_wthru, rsp_oram, rsp_ctrl, rsp_violation, rsp_miss;
    logic [2:0]  rsp_space;
    logic        rsp_timing;

    va_attr_resolver i_va_attr_resolver (.*);

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "reset";

    // reference state: expected contents of the response stage
    logic        ev = 0;
    logic [31:0] e_pa;
    logic        e_c, e_wt, e_ram, e_cr, e_vi, e_ms, e_tc;
    logic [2:0]  e_sa;

    task automatic chk(string req, string fld, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s [%s]: actual %h expected %h", req, fld, tag, act, exp);
        end
    endtask

    task automatic model_load();
        int  ow;
        bit  mapped, ram, sq, tr, hit_ok, cr_area;
        logic [31:0] phys, base;
        mapped = (req_region == 0) || (req_region == 3) || (req_region == 5);
        ram    = oram_on && (req_region == 0 || req_region == 5) && (req_vaddr[31:26] == 6'h1F);
        sq     = (req_region == 4) && (req_vaddr[31:26] == 6'h38);
        tr     = (mapped && !ram) || sq;
        case (tlb_pg_size)
            2'd0: ow = 10;
            2'd1: ow = 12;
            2'd2: ow = 16;
            default: ow = 20;
        endcase
        base = {tlb_ppn, 10'd0};
        phys = ((base >> ow) << ow) | (req_vaddr % (32'd1 << ow));
        hit_ok  = tr && tlb_hit;
        cr_area = hit_ok && (phys[28:26] == 3'd7);
        e_ms  = tr && !tlb_hit;
        e_ram = ram;
        e_cr  = cr_area;
        e_pa  = e_ms ? 32'd0 : (tr ? phys : req_vaddr);
        e_c   = hit_ok && cache_on && tlb_cache && !cr_area;
        e_wt  = e_c && req_write && tlb_wthru;
        e_vi  = (cr_area && tlb_cache)
              || (req_user && !req_dma && req_region != 5)
              || (!tr && !mapped && !req_dma
                  && (req_vaddr[28:26] == 3'd5 || req_vaddr[28:26] == 3'd6));
        if (e_ms) begin
            e_sa = 0; e_tc = 0;
        end else if (req_dma) begin
            e_sa = dma_space; e_tc = dma_timing;
        end else if (tr) begin
            e_sa = tlb_space; e_tc = tlb_timing;
        end else begin
            e_sa = 0; e_tc = 0;
        end
    endtask

    task automatic step();
        #1;
        chk("R11", "req_ready", req_ready, !ev || rsp_ready);
        if (!ev || rsp_ready) begin
            if (req_valid) begin
                model_load();
                ev = 1;
            end else begin
                ev = 0;
            end
        end
        @(negedge clk);
        chk("R11", "rsp_valid", rsp_valid, ev);
        if (ev) begin
            chk("R1", "paddr", rsp_paddr, e_pa);
            chk("R2", "cacheable", rsp_cacheable, e_c);
            chk("R3", "wthru", rsp_wthru, e_wt);
            chk("R4", "oram", rsp_oram, e_ram);
            chk("R6", "ctrl", rsp_ctrl, e_cr);
            chk("R8", "space", rsp_space, e_sa);
            chk("R8", "timing", rsp_timing, e_tc);
            chk("R9", "violation", rsp_violation, e_vi);
            chk("R10", "miss", rsp_miss, e_ms);
        end
    endtask

    task automatic base_req(logic [2:0] rg, logic [31:0] va);
        req_valid = 1; rsp_ready = 1; req_region = rg; req_vaddr = va;
        req_user = 0; req_write = 0; req_dma = 0;
        tlb_hit = 1; tlb_pg_size = 2'd1; tlb_ppn = 22'h12345;
        tlb_cache = 0; tlb_wthru = 0; tlb_space = 3'd4; tlb_timing = 1;
        dma_space = 3'd2; dma_timing = 0; cache_on = 1; oram_on = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R12 reset";
        chk("R12", "rsp_valid", rsp_valid, 0);
        rst = 0;

        // R1: every page size on a mapped region
        for (int s = 0; s < 4; s++) begin
            tag = "R1 page sizes";
            base_req(3'd0, 32'h1234_5678); tlb_pg_size = s[1:0]; tlb_ppn = 22'h2A_AAAA;
            step();
        end
        // R2 / R3: cache enable, C and WT combinations with writes
        for (int k = 0; k < 16; k++) begin
            tag = "R2 R3 policy";
            base_req(3'd3, 32'h0040_0100);
            cache_on = k[0]; tlb_cache = k[1]; tlb_wthru = k[2]; req_write = k[3];
            step();
        end
        // R4: on-chip RAM window in U0 and P0, no hit, and the same address with RAM off
        tag = "R4 oram";
        base_req(3'd5, 32'h7C00_1230); oram_on = 1; tlb_hit = 0; step();
        base_req(3'd0, 32'h7FFF_FFF8); oram_on = 1; tlb_hit = 0; req_write = 1; step();
        base_req(3'd0, 32'h7C00_0040); oram_on = 0; tlb_hit = 1; step();
        // R5: fixed regions pass through, store-queue window translates
        tag = "R5 fixed and sq";
        base_req(3'd1, 32'h8123_4560); step();
        base_req(3'd2, 32'hA000_0010); step();
        base_req(3'd4, 32'hE000_0020); tlb_ppn = 22'h03_0000; step();
        base_req(3'd4, 32'hFF00_0000); step();
        // R6 / R7: control-register area with C clear and set
        tag = "R6 R7 ctrl area";
        base_req(3'd5, 32'h0000_0400); tlb_ppn = 22'h07_0000; tlb_cache = 0; step();
        base_req(3'd5, 32'h0000_0400); tlb_ppn = 22'h07_0001; tlb_cache = 1; step();
        // R8 / R9: DMA source fields and interface-area rejection
        tag = "R8 R9 dma and ifa";
        base_req(3'd2, 32'hB400_0000); step();
        base_req(3'd2, 32'hB400_0000); req_dma = 1; step();
        base_req(3'd0, 32'h0001_0000); req_dma = 1; step();
        base_req(3'd1, 32'h9800_0000); step();
        // R10: miss on a mapped region
        tag = "R10 miss";
        base_req(3'd3, 32'hC000_1000); tlb_hit = 0; req_dma = 1; step();
        // R13: user mode outside U0
        tag = "R13 user mode";
        base_req(3'd0, 32'h0000_2000); req_user = 1; step();
        base_req(3'd5, 32'h0000_2000); req_user = 1; step();

        // random traffic with stalls (R11 hold behaviour)
        tag = "random";
        for (int n = 0; n < 4000; n++) begin
            int w;
            w = $urandom % 5;
            req_valid   = ($urandom % 4) != 0;
            rsp_ready   = ($urandom % 3) != 0;
            req_region  = 3'($urandom % 8);
            req_vaddr   = $urandom;
            if (w == 0) req_vaddr[31:26] = 6'h1F;
            if (w == 1) req_vaddr[31:26] = 6'h38;
            if (w == 2) req_vaddr[28:26] = 3'd5 + 3'($urandom % 2);
            req_user    = ($urandom % 4) == 0;
            req_write   = $urandom;
            req_dma     = ($urandom % 4) == 0;
            tlb_hit     = ($urandom % 5) != 0;
            tlb_pg_size = $urandom;
            tlb_ppn     = $urandom;
            if (w == 3) tlb_ppn[18:16] = 3'd7;
            tlb_cache   = $urandom;
            tlb_wthru   = $urandom;
            tlb_space   = $urandom;
            tlb_timing  = $urandom;
            dma_space   = $urandom;
            dma_timing  = $urandom;
            cache_on    = ($urandom % 4) != 0;
            oram_on     = $urandom;
            step();
        end
        req_valid = 0;
        rsp_ready = 1;
        step();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule